// File: doc/BRIEF.md
# Interrupt Polarity Normalizing Adapter

This block sits between a set of peripheral interrupt lines and a parent interrupt controller that accepts only active-high level requests. Each line can be masked, can have its sense reversed so that a low level or a falling edge counts as active, and can be set to edge or level handling. Edge lines are caught in a per-line latch that holds the request until software writes a 1 to that line's end-of-interrupt bit. Every output therefore reaches the parent as an active-high level.

Each input passes through a multi-flop synchronizer. An edge is found by comparing the current synchronized value with the value one cycle earlier, taking the line's polarity into account. Configuration sits in 16-bit registers. Each register serves 16 lines, and consecutive registers of a group lie 4 bytes apart.

Top module: `ipn_top`

## Requirements
- R1: After reset every line is masked (mask registers read 0xFFFF), polarity and mode registers read 0, all latches are empty, and `irq_out` is all zero.
- R2: Word-aligned write and read offsets below 0x40 select a group with bits [5:4] (0: mask, 1: polarity, 2: end-of-interrupt, 3: mode) and a register with bits [3:2]. Register k of a group covers lines 16k to 16k+15, and bit j belongs to line 16k+j. Reads of mask, polarity and mode return the stored value. Reads of the end-of-interrupt group return 0.
- R3: A line with mode bit 0 (level) drives `irq_out` with its synchronized input XOR its polarity bit while it is unmasked. An input change shows up SYNC_STAGES cycles later. A polarity write takes effect on the cycle after the write.
- R4: A line with mode bit 1 (edge) latches a request on a rising synchronized input when polarity is 0, or on a falling one when polarity is 1. The output rises SYNC_STAGES+1 cycles after the input change and stays high after the input returns.
- R5: Writing 1 to a line's end-of-interrupt bit clears its latch at that write. Bits written as 0 leave other latches alone.
- R6: If a new edge and an end-of-interrupt for the same line arrive on the same cycle, the latch stays set.
- R7: A mask bit of 1 forces the line's output to 0 but keeps its latch. Clearing the mask shows a held request on the next cycle.
- R8: End-of-interrupt writes have no effect on level lines.
- R9: Changing a polarity bit while the input is steady does not latch a request.
- R10: A latch is emptied while its line is in level mode. A request held before a switch to level is not shown again after a switch back to edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Raw peripheral interrupt lines |
| irq_out | output | NUM_LINES | Active-high level requests to the parent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Read data, combinational |

## Verification
The bench builds the block with NUM_LINES=64 and SYNC_STAGES=2. That makes all four registers of each group usable, including the top slot at offset 0x0C, whose partial mask is checked lane by lane. It also fixes the level and edge latencies at two and three cycles. With these fixed latencies the scoreboard can time the race between an edge and an end-of-interrupt write so that both land on the same clock edge.

// File: rtl/ipn_pkg.sv
package ipn_pkg;
   localparam int unsigned LANE_W   = 16;
   localparam int unsigned ADDR_W   = 8;
   localparam int unsigned SLOT_MAX = 4;

   typedef enum logic [1:0] {
      GRP_MASK = 2'd0,
      GRP_POL  = 2'd1,
      GRP_EOI  = 2'd2,
      GRP_MODE = 2'd3
   } grp_e;

   typedef struct packed {
      logic [1:0] top;
      grp_e       grp;
      logic [1:0] slot;
      logic [1:0] byte_off;
   } addr_t;
endpackage

// File: rtl/ipn_sync.sv
module ipn_sync #(
   parameter int unsigned W      = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ipn_regs.sv
module ipn_regs
   import ipn_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [LANE_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [LANE_W-1:0]    rd_data,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] pol_q,
   output logic [NUM_LINES-1:0] mode_q,
   output logic [NUM_LINES-1:0] eoi_vec
);
   localparam int unsigned NSLOT = NUM_LINES / LANE_W;

   addr_t wa;
   addr_t ra;
   logic  wr_ok;
   logic  rd_ok;

   assign wa    = addr_t'(wr_addr);
   assign ra    = addr_t'(rd_addr);
   assign wr_ok = wr_en && (wa.top == 2'd0) && (wa.byte_off == 2'd0);
   assign rd_ok = (ra.top == 2'd0) && (ra.byte_off == 2'd0);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic              sel;
      logic [LANE_W-1:0] m_r;
      logic [LANE_W-1:0] p_r;
      logic [LANE_W-1:0] d_r;

      assign sel = wr_ok && (wa.slot == 2'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_r <= '1;
            p_r <= '0;
            d_r <= '0;
         end else if (sel) begin
            case (wa.grp)
               GRP_MASK: m_r <= wr_data;
               GRP_POL:  p_r <= wr_data;
               GRP_MODE: d_r <= wr_data;
               default:  ;
            endcase
         end
      end

      assign mask_q[s*LANE_W +: LANE_W]  = m_r;
      assign pol_q[s*LANE_W +: LANE_W]   = p_r;
      assign mode_q[s*LANE_W +: LANE_W]  = d_r;
      assign eoi_vec[s*LANE_W +: LANE_W] = (sel && wa.grp == GRP_EOI) ? wr_data : '0;
   end

   always_comb begin
      rd_data = '0;
      if (rd_ok) begin
         for (int s = 0; s < NSLOT; s++) begin
            if (ra.slot == 2'(s)) begin
               case (ra.grp)
                  GRP_MASK: rd_data = mask_q[s*LANE_W +: LANE_W];
                  GRP_POL:  rd_data = pol_q[s*LANE_W +: LANE_W];
                  GRP_MODE: rd_data = mode_q[s*LANE_W +: LANE_W];
                  default:  rd_data = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/ipn_lines.sv
module ipn_lines #(
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] cur,
   input  logic [NUM_LINES-1:0] pol,
   input  logic [NUM_LINES-1:0] mode,
   input  logic [NUM_LINES-1:0] mask,
   input  logic [NUM_LINES-1:0] eoi,
   output logic [NUM_LINES-1:0] irq_out,
   output logic [NUM_LINES-1:0] latch_q,
   output logic [NUM_LINES-1:0] edge_hit
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic prev_r;
      logic lat_r;
      logic hit;
      logic req;

      // Edge found on the raw synchronized value, so a polarity flip alone
      // never looks like a transition.
      assign hit = pol[i] ? (prev_r & ~cur[i]) : (cur[i] & ~prev_r);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_r <= 1'b0;
         else        prev_r <= cur[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lat_r <= 1'b0;
         else if (!mode[i]) lat_r <= 1'b0;
         else if (hit)    lat_r <= 1'b1;
         else if (eoi[i]) lat_r <= 1'b0;
      end

      assign req         = mode[i] ? lat_r : (cur[i] ^ pol[i]);
      assign irq_out[i]  = req & ~mask[i];
      assign latch_q[i]  = lat_r;
      assign edge_hit[i] = hit;
   end
endmodule

// File: rtl/ipn_top.sv
module ipn_top
   import ipn_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] irq_out,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [LANE_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [LANE_W-1:0]    rd_data
);
   if (NUM_LINES == 0 || (NUM_LINES % LANE_W) != 0 || NUM_LINES > LANE_W * SLOT_MAX) begin : g_bad_lines
      $error("NUM_LINES must be a nonzero multiple of 16 and at most 64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] cur;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] pol_q;
   logic [NUM_LINES-1:0] mode_q;
   logic [NUM_LINES-1:0] eoi_vec;
   logic [NUM_LINES-1:0] latch_q;
   logic [NUM_LINES-1:0] edge_hit;

   ipn_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (cur)
   );

   ipn_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .mask_q  (mask_q),
      .pol_q   (pol_q),
      .mode_q  (mode_q),
      .eoi_vec (eoi_vec)
   );

   ipn_lines #(.NUM_LINES(NUM_LINES)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (cur),
      .pol      (pol_q),
      .mode     (mode_q),
      .mask     (mask_q),
      .eoi      (eoi_vec),
      .irq_out  (irq_out),
      .latch_q  (latch_q),
      .edge_hit (edge_hit)
   );
endmodule

// File: rtl/ipn_checker.sv
module ipn_checker #(
   parameter int unsigned NUM_LINES = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_out,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] mode_q,
   input logic [NUM_LINES-1:0] latch_q,
   input logic [NUM_LINES-1:0] edge_hit,
   input logic [NUM_LINES-1:0] eoi_vec
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[i] |-> !irq_out[i]);
      p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_q[i] && mode_q[i] && !eoi_vec[i]) |=> latch_q[i]);
      p_eoi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && eoi_vec[i] && !edge_hit[i]) |=> !latch_q[i]);
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && edge_hit[i]) |=> latch_q[i]);
      p_level_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !mode_q[i] |=> !latch_q[i]);
      p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(latch_q[i]) |-> $past(edge_hit[i]));
   end
endmodule

bind ipn_top ipn_checker #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_out  (irq_out),
   .mask_q   (mask_q),
   .mode_q   (mode_q),
   .latch_q  (latch_q),
   .edge_hit (edge_hit),
   .eoi_vec  (eoi_vec)
);

// File: tb/sim_ipn_top.sv
module sim_ipn_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NL-1:0] din;
   logic [NL-1:0] irq_out;
   logic          wr_en;
   logic [7:0]    wr_addr;
   logic [15:0]   wr_data;
   logic [7:0]    rd_addr;
   logic [15:0]   rd_data;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct {
      int          due;
      logic [63:0] care;
      logic [63:0] val;
      string       tag;
   } item_t;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ipn_top #(.NUM_LINES(NL), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(din), .irq_out(irq_out),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic note(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard entries that fall due on this cycle
   always @(negedge clk) begin
      for (int k = q.size() - 1; k >= 0; k--) begin
         if (q[k].due == cyc) begin
            note((irq_out & q[k].care) === (q[k].val & q[k].care), q[k].tag,
                 irq_out & q[k].care, q[k].val & q[k].care);
            q.delete(k);
         end
      end
   end

   task automatic expect_out(input int lat, input logic [63:0] care, input logic [63:0] val, input string tag);
      item_t it;
      it.due = cyc + lat; it.care = care; it.val = val; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [15:0] e, input string tag);
      rd_addr = a;
      #1;
      note(rd_data === e, tag, 64'(rd_data), 64'(e));
   endtask

   function automatic logic [63:0] bt(input int n);
      return 64'(1) << n;
   endfunction

   localparam logic [63:0] PAT_A = 64'h0123_4567_89AB_CDEF;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; din = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      step(4);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      note(irq_out === '0, "R1 outputs idle", irq_out, '0);
      for (int s = 0; s < 4; s++) begin
         chk_rd(8'(s*4), 16'hFFFF, "R1 mask reset");
         chk_rd(8'(8'h10 + s*4), 16'h0000, "R1 pol reset");
         chk_rd(8'(8'h30 + s*4), 16'h0000, "R1 mode reset");
      end
      din = '1;
      expect_out(3, '1, '0, "R7 masked after reset");
      step(3);

      // R3 level pass-through
      for (int s = 0; s < 4; s++) wr(8'(s*4), 16'h0000);
      expect_out(1, '1, '1, "R3 all high");
      step(2);
      din = PAT_A;
      expect_out(1, '1, '1, "R3 latency not early");
      expect_out(2, '1, PAT_A, "R3 pattern A");
      step(3);
      wr(8'h14, 16'hFFFF);
      expect_out(1, '1, PAT_A ^ 64'h0000_0000_FFFF_0000, "R3 R2 polarity slot1");
      step(2);
      chk_rd(8'h14, 16'hFFFF, "R2 pol readback");
      wr(8'h14, 16'h0000);
      wr(8'h0C, 16'hF0F0);
      expect_out(1, 64'hFFFF_0000_0000_0000, 64'h0103_0000_0000_0000, "R2 R7 partial mask slot3");
      step(2);
      wr(8'h0C, 16'h0000);

      // R4 edge mode on lines 0..15
      din[15:0] = '0;
      step(3);
      wr(8'h30, 16'hFFFF);
      chk_rd(8'h30, 16'hFFFF, "R2 mode readback");
      step(2);
      expect_out(1, 64'hFFFF, '0, "R4 latches empty");
      step(2);
      din[0] = 1'b1;
      expect_out(2, bt(0), '0, "R4 rise not yet latched");
      expect_out(3, bt(0), bt(0), "R4 rise latched");
      step(4);
      din[0] = 1'b0;
      expect_out(3, bt(0), bt(0), "R4 held after input drop");
      step(4);
      din[1] = 1'b1;
      step(4);
      wr(8'h20, 16'h0001);
      expect_out(1, bt(0) | bt(1), bt(1), "R5 eoi clears only line 0");
      step(2);
      wr(8'h20, 16'h0002);
      expect_out(1, bt(1), '0, "R5 eoi clears line 1");
      step(2);

      // R9 polarity flip without edge; R4 falling edge
      wr(8'h10, 16'h0004);
      step(3);
      expect_out(1, bt(2), '0, "R9 no latch on polarity flip");
      step(2);
      din[2] = 1'b1;
      step(4);
      expect_out(1, bt(2), '0, "R4 rise ignored with reversed sense");
      step(2);
      din[2] = 1'b0;
      expect_out(3, bt(2), bt(2), "R4 falling edge latched");
      step(4);

      // R7 mask keeps latch
      wr(8'h00, 16'h0008);
      din[3] = 1'b1;
      step(4);
      expect_out(1, bt(3), '0, "R7 masked latched line low");
      step(2);
      wr(8'h00, 16'h0000);
      expect_out(1, bt(3), bt(3), "R7 unmask shows held request");
      step(2);

      // R6 edge and eoi on the same edge
      din[4] = 1'b1;
      step(2);
      wr(8'h20, 16'h0010);
      expect_out(1, bt(4), bt(4), "R6 set wins");
      expect_out(3, bt(4), bt(4), "R6 set wins later");
      step(4);
      wr(8'h20, 16'h0010);
      expect_out(1, bt(4), '0, "R5 clear after race");
      step(2);

      // R8 level line ignores eoi
      din[20] = 1'b1;
      step(3);
      wr(8'h24, 16'hFFFF);
      expect_out(1, bt(20), bt(20), "R8 level ignores eoi");
      expect_out(2, bt(20), bt(20), "R8 level ignores eoi later");
      step(3);

      // R10 switch to level discards latch
      din[5] = 1'b1;
      step(4);
      din[5] = 1'b0;
      step(3);
      expect_out(1, bt(5), bt(5), "R10 line 5 latched");
      step(2);
      wr(8'h30, 16'hFFDF);
      expect_out(1, bt(5), '0, "R10 level shows input");
      step(2);
      wr(8'h30, 16'hFFFF);
      expect_out(1, bt(5), '0, "R10 latch discarded");
      expect_out(3, bt(5), '0, "R10 latch discarded later");
      step(4);

      chk_rd(8'h10, 16'h0004, "R2 pol slot0 readback");
      chk_rd(8'h20, 16'h0000, "R2 eoi reads zero");
      chk_rd(8'h00, 16'h0000, "R2 mask slot0 readback");
      step(4);
      note(q.size() == 0, "scoreboard drained", 64'(q.size()), '0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule